// File: doc/BRIEF.md
# Off-Core Request Latency Monitor

This block watches a core's off-core memory traffic and gives software what it needs to compute the mean request latency. Each cycle it may see one request issue, tagged with an ID and a request-type vector, and one request completion, tagged with an ID, a type vector and a response/snoop information vector. Two event counters, each 48 bits wide, are tied to two configuration registers. Each configuration register selects request types, response conditions, an enable and, on the first register only, a weighted mode.

In weighted mode, counter 0 adds the number of outstanding tracked requests on every cycle. A tracker follows those requests by ID. It counts a request when the request issues with a type that configuration register 0 selects, and it releases the request when a completion with the same ID arrives. In count mode, a counter adds one for each completion whose type and response match its register. Program both registers with the same type mask, counter 0 weighted and counter 1 counting any response. Then counter 0 divided by counter 1 is the mean latency in cycles. The division is left to software.

All configuration and counter access goes through one register port with a write strobe, a 2-bit address and combinational read data.

Top module: `req_lat_mon`

## Requirements
- R1: After reset, both configuration registers and both counters read as zero.
- R2: Address 0 is config 0, address 1 is config 1, address 2 is counter 0 and address 3 is counter 1. In config 0 the writable bits are [31:0], 33, 34, 36, 37, 38 and 40. Config 1 has the same writable bits except bit 38. All other config bits read as zero. Writing all ones therefore reads back 0x176FFFFFFFF from config 0 and 0x136FFFFFFFF from config 1.
- R3: A request or completion matches a register only if its type vector shares at least one set bit with that register's bits [15:0].
- R4: The outstanding count rises by one on an issue that matches config 0's type mask and whose ID is not already outstanding. It falls by one only on a completion whose ID is outstanding. A completion for any other ID leaves the count unchanged, so the count never goes below zero.
- R5: An issue and a completion that are both counted in the same cycle leave the outstanding count unchanged.
- R6: When config 0 has bit 38 (weighted) and bit 40 (enable) set, counter 0 adds, at each clock edge, the outstanding count held before that edge.
- R7: In count mode, an enabled counter adds one for each completion whose type matches. The completion must also satisfy one of two response conditions: config bit 16 (any response) is set, or the completion info vector shares a set bit with config bits [37:17]. Info bit k corresponds to config bit 17+k. Config bit 33 means snoop miss, 34 means clean snoop hit, 36 means modified hit, 37 means non-DRAM target and 31 means no snoop info.
- R8: When a counter's enable bit 40 is clear, its counter holds its value, even while requests are outstanding.
- R9: A write to a counter address loads write-data bits [47:0]. The load takes priority over accumulation in that cycle. Counter reads return zero in bits [63:48].
- R10: Counters wrap from 0xFFFFFFFFFFFF to zero without any other effect.
- R11: When both registers hold the same type mask, with counter 0 weighted and counter 1 counting any response, counter 0 divided by counter 1 equals the mean number of cycles from issue to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | Request issued this cycle |
| iss_id | input | ID_W | ID of the issued request |
| iss_type | input | 16 | Type vector of the issued request |
| cmp_vld | input | 1 | Request completed this cycle |
| cmp_id | input | ID_W | ID of the completed request |
| cmp_type | input | 16 | Type vector of the completed request |
| cmp_info | input | 21 | Response/snoop info, bit k matching config bit 17+k |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |

## Verification
Two pairs of events can land on the same clock edge. The first pair is an issue and a completion in the tracker. The second pair is a software load of a counter and that counter's own accumulation. The first pair is provoked by issuing a new request in the cycle another request completes, inside a latency run. It is judged through the weighted total, which is exact only if the outstanding count holds steady at that edge. The second pair is provoked by loading counter 0 while it is enabled in weighted mode with two requests outstanding. The readback must show the loaded value plus exactly one cycle's worth of outstanding requests.

// File: rtl/rlm_pkg.sv
package rlm_pkg;
    localparam int REG_W   = 64;
    localparam int TYPE_W  = 16;
    localparam int ANY_BIT = 16;
    localparam int INFO_LO = 17;
    localparam int INFO_HI = 37;
    localparam int INFO_W  = INFO_HI - INFO_LO + 1;
    localparam int WT_BIT  = 38;
    localparam int EN_BIT  = 40;

    localparam logic [1:0] ADDR_CFG0 = 2'd0;
    localparam logic [1:0] ADDR_CFG1 = 2'd1;
    localparam logic [1:0] ADDR_CTR0 = 2'd2;
    localparam logic [1:0] ADDR_CTR1 = 2'd3;

    // Writable bits of a configuration register; weighted bit only where allowed.
    function automatic logic [REG_W-1:0] cfg_wmask(input logic wt_ok);
        logic [REG_W-1:0] m;
        m              = '0;
        m[INFO_HI:0]   = '1;
        m[32]          = 1'b0;
        m[35]          = 1'b0;
        m[WT_BIT]      = wt_ok;
        m[EN_BIT]      = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/rlm_match.sv
module rlm_match
    import rlm_pkg::*;
(
    input  logic              cmp_vld,
    input  logic [TYPE_W-1:0] cmp_type,
    input  logic [INFO_W-1:0] cmp_info,
    input  logic [TYPE_W-1:0] cfg_type,
    input  logic              cfg_any,
    input  logic [INFO_W-1:0] cfg_info,
    output logic              hit
);
    logic type_hit;
    logic resp_hit;

    always_comb begin
        type_hit = |(cmp_type & cfg_type);
        resp_hit = cfg_any || (|(cmp_info & cfg_info));
        hit      = cmp_vld && type_hit && resp_hit;
    end
endmodule

// File: rtl/rlm_track.sv
module rlm_track #(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_fire,
    input  logic [ID_W-1:0] iss_id,
    input  logic            cmp_vld,
    input  logic [ID_W-1:0] cmp_id,
    output logic [ID_W:0]   outst,
    output logic            inc,
    output logic            dec
);
    localparam int DEPTH = 1 << ID_W;
    localparam int OUT_W = ID_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0] pend;
        logic [OUT_W-1:0] cnt;
    } trk_t;

    trk_t trk_q, trk_d;

    always_comb begin
        trk_d = trk_q;
        inc   = iss_fire && !trk_q.pend[iss_id];
        dec   = cmp_vld && trk_q.pend[cmp_id];
        if (dec) trk_d.pend[cmp_id] = 1'b0;
        if (inc) trk_d.pend[iss_id] = 1'b1;
        if (inc && !dec) begin
            trk_d.cnt = trk_q.cnt + OUT_W'(1);
        end else if (dec && !inc && (trk_q.cnt != '0)) begin
            trk_d.cnt = trk_q.cnt - OUT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign outst = trk_q.cnt;
endmodule

// File: rtl/rlm_counter.sv
module rlm_counter #(
    parameter int CNT_W = 48,
    parameter int ADD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             weighted,
    input  logic [ADD_W-1:0] wt_add,
    input  logic             ev,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] value
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_t;

    cnt_t cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.val = load_val;
        end else if (en) begin
            if (weighted)  cnt_d.val = cnt_q.val + CNT_W'(wt_add);
            else if (ev)   cnt_d.val = cnt_q.val + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q.val;
endmodule

// File: rtl/req_lat_mon.sv
module req_lat_mon
    import rlm_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int CNT_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_vld,
    input  logic [ID_W-1:0]   iss_id,
    input  logic [TYPE_W-1:0] iss_type,
    input  logic              cmp_vld,
    input  logic [ID_W-1:0]   cmp_id,
    input  logic [TYPE_W-1:0] cmp_type,
    input  logic [INFO_W-1:0] cmp_info,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam int OUT_W = ID_W + 1;
    localparam int NCTR  = 2;

    typedef struct packed {
        logic [REG_W-1:0] cfg0;
        logic [REG_W-1:0] cfg1;
    } cfg_t;

    cfg_t             cfg_q, cfg_d;
    logic [REG_W-1:0] cfg_w [NCTR];
    logic [CNT_W-1:0] ctr_w [NCTR];
    logic [OUT_W-1:0] outst;
    logic             trk_inc;
    logic             trk_dec;
    logic             iss_fire;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr && (reg_addr == ADDR_CFG0)) cfg_d.cfg0 = reg_wdata & cfg_wmask(1'b1);
        if (reg_wr && (reg_addr == ADDR_CFG1)) cfg_d.cfg1 = reg_wdata & cfg_wmask(1'b0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_w[0] = cfg_q.cfg0;
    assign cfg_w[1] = cfg_q.cfg1;

    // Only register 0's type mask selects which issues are tracked.
    assign iss_fire = iss_vld && (|(iss_type & cfg_q.cfg0[TYPE_W-1:0]));

    rlm_track #(.ID_W(ID_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .iss_fire (iss_fire),
        .iss_id   (iss_id),
        .cmp_vld  (cmp_vld),
        .cmp_id   (cmp_id),
        .outst    (outst),
        .inc      (trk_inc),
        .dec      (trk_dec)
    );

    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
        logic ev;
        logic ld;

        rlm_match u_match (
            .cmp_vld  (cmp_vld),
            .cmp_type (cmp_type),
            .cmp_info (cmp_info),
            .cfg_type (cfg_w[i][TYPE_W-1:0]),
            .cfg_any  (cfg_w[i][ANY_BIT]),
            .cfg_info (cfg_w[i][INFO_HI:INFO_LO]),
            .hit      (ev)
        );

        assign ld = reg_wr && (reg_addr == (ADDR_CTR0 + 2'(i)));

        rlm_counter #(.CNT_W(CNT_W), .ADD_W(OUT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (cfg_w[i][EN_BIT]),
            .weighted (cfg_w[i][WT_BIT]),
            .wt_add   (outst),
            .ev       (ev),
            .load     (ld),
            .load_val (reg_wdata[CNT_W-1:0]),
            .value    (ctr_w[i])
        );
    end

    always_comb begin
        case (reg_addr)
            ADDR_CFG0: reg_rdata = cfg_q.cfg0;
            ADDR_CFG1: reg_rdata = cfg_q.cfg1;
            ADDR_CTR0: reg_rdata = REG_W'(ctr_w[0]);
            default:   reg_rdata = REG_W'(ctr_w[1]);
        endcase
    end
endmodule

// File: rtl/rlm_chk.sv
module rlm_chk
    import rlm_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] cfg0,
    input logic [REG_W-1:0] cfg1,
    input logic [CNT_W-1:0] ctr0,
    input logic [CNT_W-1:0] ctr1,
    input logic [ID_W:0]    outst,
    input logic             trk_inc,
    input logic             trk_dec
);
    localparam int OUT_W = ID_W + 1;

    // R2: reserved bits and the missing weighted bit of register 1 stay clear
    a_r2_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg1[WT_BIT] && !cfg0[32] && !cfg0[35] && !cfg1[32] && !cfg1[35]);

    // R4: outstanding count bounded by the number of IDs
    a_r4_outst_bound: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= OUT_W'(1 << ID_W));

    // R4: a lone release lowers the count by one
    a_r4_release_step: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_dec && !trk_inc) |=> (outst == $past(outst) - OUT_W'(1)));

    // R5: issue and release together leave the count unchanged
    a_r5_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_inc && trk_dec) |=> $stable(outst));

    // R6: weighted accumulation adds the prior outstanding count
    a_r6_weighted_add: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_wr && reg_addr == ADDR_CTR0) && cfg0[WT_BIT] && cfg0[EN_BIT])
        |=> (ctr0 == ($past(ctr0) + CNT_W'($past(outst)))));

    // R8: a disabled counter holds
    a_r8_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_wr && reg_addr == ADDR_CTR1) && !cfg1[EN_BIT]) |=> $stable(ctr1));

    // R9: a write loads the low bits of the write data
    a_r9_load_ctr0: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTR0) |=> (ctr0 == $past(reg_wdata[CNT_W-1:0])));
endmodule

bind req_lat_mon rlm_chk #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cfg0      (cfg_q.cfg0),
    .cfg1      (cfg_q.cfg1),
    .ctr0      (ctr_w[0]),
    .ctr1      (ctr_w[1]),
    .outst     (outst),
    .trk_inc   (trk_inc),
    .trk_dec   (trk_dec)
);

// File: tb/tb_req_lat_mon.sv
module tb_req_lat_mon;
    localparam int ID_W  = 4;
    localparam int CNT_W = 48;

    localparam logic [63:0] EN   = 64'd1 << 40;
    localparam logic [63:0] WT   = 64'd1 << 38;
    localparam logic [63:0] ANY  = 64'd1 << 16;
    localparam logic [63:0] MISS = 64'd1 << 33;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            iss_vld = 1'b0;
    logic [ID_W-1:0] iss_id = '0;
    logic [15:0]     iss_type = '0;
    logic            cmp_vld = 1'b0;
    logic [ID_W-1:0] cmp_id = '0;
    logic [15:0]     cmp_type = '0;
    logic [20:0]     cmp_info = '0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_addr = '0;
    logic [63:0]     reg_wdata = '0;
    logic [63:0]     reg_rdata;

    always #10 clk = ~clk;

    req_lat_mon #(.ID_W(ID_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .iss_vld(iss_vld), .iss_id(iss_id), .iss_type(iss_type),
        .cmp_vld(cmp_vld), .cmp_id(cmp_id), .cmp_type(cmp_type), .cmp_info(cmp_info),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct {
        logic [1:0]  addr;
        logic [63:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];
    sb_item_t cur;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Monitor: compares the read data against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            cur = sb.pop_front();
            n_cmp++;
            if (reg_rdata !== cur.exp) begin
                n_bad++;
                $display("FAIL %s: addr %0d got 0x%h expected 0x%h",
                         cur.tag, cur.addr, reg_rdata, cur.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        iss_vld = 1'b0;
        cmp_vld = 1'b0;
        reg_wr  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [63:0] e, input string tag);
        sb_item_t it;
        reg_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic set_iss(input logic [ID_W-1:0] id, input logic [15:0] t);
        iss_vld = 1'b1; iss_id = id; iss_type = t;
    endtask

    task automatic set_cmp(input logic [ID_W-1:0] id, input logic [15:0] t, input logic [20:0] info);
        cmp_vld = 1'b1; cmp_id = id; cmp_type = t; cmp_info = info;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset values
        expect_reg(2'd0, 64'h0, "R1 cfg0");
        expect_reg(2'd1, 64'h0, "R1 cfg1");
        expect_reg(2'd2, 64'h0, "R1 ctr0");
        expect_reg(2'd3, 64'h0, "R1 ctr1");

        // R2: writable bits
        wr(2'd0, '1);
        wr(2'd1, '1);
        expect_reg(2'd0, 64'h0000_0176_FFFF_FFFF, "R2 cfg0 mask");
        expect_reg(2'd1, 64'h0000_0136_FFFF_FFFF, "R2 cfg1 mask");
        wr(2'd0, 64'h0);
        wr(2'd1, 64'h0);

        // R4 R5 R6 R11: latency run, three requests of 5, 4 and 3 cycles
        wr(2'd0, 64'h1 | WT | EN);
        wr(2'd1, 64'h1 | ANY | EN);
        set_cmp(4'd9, 16'h2, 21'h0);          step(); // e0: completion with no pending ID, count at zero
        set_iss(4'd1, 16'h1);                 step(); // e1
        set_iss(4'd4, 16'h2);                 step(); // e2: type not selected
        set_iss(4'd2, 16'h1);                 step(); // e3
        set_cmp(4'd7, 16'h2, 21'h0);          step(); // e4: never-issued ID
        idle(1);                                      // e5
        set_cmp(4'd1, 16'h1, 21'h0);          step(); // e6
        set_cmp(4'd2, 16'h1, 21'h0);
        set_iss(4'd3, 16'h1);                 step(); // e7: issue and completion together
        set_cmp(4'd4, 16'h2, 21'h0);          step(); // e8: untracked ID
        idle(1);                                      // e9
        set_cmp(4'd3, 16'h1, 21'h0);          step(); // e10
        wr(2'd0, 64'h1);
        wr(2'd1, 64'h0);
        expect_reg(2'd2, 64'd12, "R6 R4 R5 weighted total");
        expect_reg(2'd3, 64'd3,  "R7 R11 request count");
        expect_reg(2'd2, 64'd4 * 64'd3, "R11 weighted equals mean 4 times count");

        // R7 R3: response and type matching in count mode
        wr(2'd3, 64'h0);
        wr(2'd1, 64'h4 | MISS | EN);
        set_cmp(4'd0, 16'h4, 21'h1 << 17);           step(); // clean hit only
        set_cmp(4'd0, 16'h4, 21'h1 << 16);           step(); // miss
        set_cmp(4'd0, 16'h8, 21'h1 << 16);           step(); // wrong type
        set_cmp(4'd0, 16'hC, (21'h1 << 19) | (21'h1 << 16)); step(); // type overlaps, miss present
        set_cmp(4'd0, 16'h4, 21'h0);                 step(); // no info
        wr(2'd1, 64'h0);
        expect_reg(2'd3, 64'd2, "R7 R3 response match count");

        // R8: disabled counter holds while requests are outstanding
        set_iss(4'd5, 16'h1); step();
        set_iss(4'd6, 16'h1); step();
        idle(3);
        expect_reg(2'd2, 64'd12, "R8 disabled hold");

        // R9: load wins over accumulation in the same cycle
        wr(2'd0, 64'h1 | WT | EN);
        wr(2'd2, 64'd100);
        wr(2'd0, 64'h1);
        expect_reg(2'd2, 64'd102, "R9 load priority");
        set_cmp(4'd5, 16'h2, 21'h0); step();
        set_cmp(4'd6, 16'h2, 21'h0); step();

        // R4: all released, weighted run adds nothing
        wr(2'd2, 64'h0);
        wr(2'd0, 64'h1 | WT | EN);
        idle(4);
        wr(2'd0, 64'h1);
        expect_reg(2'd2, 64'd0, "R4 count back to zero");

        // R9 R10: width of load and wrap
        wr(2'd3, '1);
        expect_reg(2'd3, 64'h0000_FFFF_FFFF_FFFF, "R9 load width");
        wr(2'd1, 64'h1 | ANY | EN);
        set_cmp(4'd0, 16'h1, 21'h0); step();
        wr(2'd1, 64'h0);
        expect_reg(2'd3, 64'd0, "R10 wrap to zero");

        idle(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule